// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control core of a multi-channel successive-approximation converter that sits on a parallel host bus. The host writes a short control word with the write strobe and chip select both active. That word picks the input channel and the output coding, and says whether the sample window is timed by the block or held open by the host. The block then steps through a sample window and a fixed-length conversion. When the result is ready it pulls an active-low ready flag. On a read it presents the 12-bit result, with an output-enable that steers an external tri-state pad ring.

The analog front end is not part of the block. The comparator is stood in for by a single decision input, `bit_in`, which is sampled once per conversion step with the most significant decision first. Any new control word that arrives during a conversion abandons that conversion and opens a fresh sample window with the new settings.

Top module: `adc_seq_core`

## Requirements
- R1: A write is any rising clock edge at which `sel_n` and `wr_n` are both low. The control word on `ctrl_in` has this layout: bits [2:0] channel, bit 3 bipolar coding, bit 4 host-timed sampling, bit 5 conversion trigger. The channel of a non-trigger write appears on `mux_ch` after that edge.
- R2: With bit 4 clear, the sample window lasts exactly three clock cycles. `busy` goes high after the third rising edge following the write edge.
- R3: A conversion lasts exactly 13 clock cycles. At the edge that ends it, `busy` falls and `int_n` falls.
- R4: With bit 4 set, `busy` stays low until a later write with bit 5 set, and rises at that write's edge. The other fields of that trigger write are ignored: the channel and coding of the opening write are kept.
- R5: A write during a conversion abandons it. No result is stored, `int_n` stays high and `busy` falls at once. A new sample window starts with the new settings.
- R6: During conversion cycles 2 through 13, `bit_in` supplies raw code bits 11 down to 0. The stored result equals the raw code when bipolar coding was selected, and the raw code with bit 11 inverted when unipolar coding was selected.
- R7: `data_oe` is high only while `sel_n` and `rd_n` are both low. During that time `data_out` carries the stored result.
- R8: A read edge while idle sets `int_n` high. So does any write edge.
- R9: A read during a conversion returns the previous result and leaves `int_n` high.
- R10: After reset, `int_n` is 1, `busy` is 0, `data_oe` is 0, `mux_ch` is 0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ctrl_in | input | 6 | Control word captured on a write |
| bit_in | input | 1 | Comparator decision for the current step |
| data_out | output | 12 | Stored conversion result |
| data_oe | output | 1 | Enable for the external bus drivers |
| int_n | output | 1 | Result-ready flag, active low |
| busy | output | 1 | High while a conversion runs |
| mux_ch | output | 3 | Channel applied to the input multiplexer |

## Verification
The assertions assume that the host never asserts both strobes in the same cycle. They also assume that every strobe lasts a single clock cycle, so each write or read counts once.

The stimulus holds each strobe low for exactly one cycle, always with chip select. It keeps reads and writes in separate cycles. The random part draws the channel, coding, sampling mode, trigger gap and decision pattern from a fixed seed. Directed cases cover aborts, early reads and the ignored fields of a trigger write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W     = 3;
    localparam int CTRL_W   = 6;
    localparam int BIP_BIT  = 3;
    localparam int EXT_BIT  = 4;
    localparam int TRIG_BIT = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ_INT,
        ST_ACQ_EXT,
        ST_CONV
    } seq_state_e;

    typedef struct packed {
        logic            ext;
        logic            bip;
        logic [CH_W-1:0] ch;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] word);
        ctrl_t c;
        c.ch  = word[CH_W-1:0];
        c.bip = word[BIP_BIT];
        c.ext = word[EXT_BIT];
        return c;
    endfunction

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int ACQ_CYC  = 3,
    parameter int CONV_CYC = 13
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_evt,
    input  logic  trig,
    input  ctrl_t ctrl,
    output ctrl_t cur_cfg,
    output ctrl_t conv_cfg,
    output logic  busy,
    output logic  decide,
    output logic  done
);
    localparam int MAX_CYC = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur_cfg  <= '0;
            conv_cfg <= '0;
        end else if (wr_evt) begin
            cnt <= '0;
            if (state == ST_ACQ_EXT && trig) begin
                state    <= ST_CONV;
                conv_cfg <= cur_cfg;
            end else begin
                cur_cfg <= ctrl;
                state   <= ctrl.ext ? ST_ACQ_EXT : ST_ACQ_INT;
            end
        end else begin
            unique case (state)
                ST_ACQ_INT: begin
                    if (cnt == CNT_W'(ACQ_CYC - 1)) begin
                        state    <= ST_CONV;
                        cnt      <= '0;
                        conv_cfg <= cur_cfg;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_CONV: begin
                    if (cnt == CNT_W'(CONV_CYC - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        busy   = (state == ST_CONV);
        decide = busy && (cnt != '0) && !wr_evt;
        done   = busy && (cnt == CNT_W'(CONV_CYC - 1)) && !wr_evt;
    end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             decide,
    input  logic             done,
    input  logic             bip,
    input  logic             bit_in,
    output logic [RES_W-1:0] result
);
    logic [RES_W-2:0] shift;
    logic [RES_W-1:0] raw;

    function automatic logic [RES_W-1:0] apply_coding(input logic [RES_W-1:0] code,
                                                      input logic two_c);
        logic [RES_W-1:0] flip;
        flip = '0;
        flip[RES_W-1] = !two_c;
        return code ^ flip;
    endfunction

    assign raw = {shift, bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift  <= '0;
            result <= '0;
        end else begin
            if (decide) shift <= raw[RES_W-2:0];
            if (done)   result <= apply_coding(raw, bip);
        end
    end

endmodule

// File: rtl/adc_irq_ctl.sv
module adc_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic wr_evt,
    input  logic rd_evt,
    output logic int_n
);
    always_ff @(posedge clk) begin
        if (rst)                  int_n <= 1'b1;
        else if (done)            int_n <= 1'b0;
        else if (wr_evt || rd_evt) int_n <= 1'b1;
    end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int ACQ_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              bit_in,
    output logic [RES_W-1:0]  data_out,
    output logic              data_oe,
    output logic              int_n,
    output logic              busy,
    output logic [CH_W-1:0]   mux_ch
);
    localparam int CONV_CYC = RES_W + 1;

    logic  wr_evt, rd_evt, decide, done;
    ctrl_t cur_cfg, conv_cfg;

    assign wr_evt = !sel_n && !wr_n;
    assign rd_evt = !sel_n && !rd_n;

    adc_seq_fsm #(.ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC)) u_fsm (
        .clk(clk), .rst(rst), .wr_evt(wr_evt), .trig(ctrl_in[TRIG_BIT]),
        .ctrl(decode_ctrl(ctrl_in)), .cur_cfg(cur_cfg), .conv_cfg(conv_cfg),
        .busy(busy), .decide(decide), .done(done)
    );

    adc_sar_reg #(.RES_W(RES_W)) u_sar (
        .clk(clk), .rst(rst), .decide(decide), .done(done),
        .bip(conv_cfg.bip), .bit_in(bit_in), .result(data_out)
    );

    adc_irq_ctl u_irq (
        .clk(clk), .rst(rst), .done(done), .wr_evt(wr_evt),
        .rd_evt(rd_evt), .int_n(int_n)
    );

    assign data_oe = rd_evt;
    assign mux_ch  = cur_cfg.ch;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_n,
    input logic             wr_n,
    input logic             rd_n,
    input logic [RES_W-1:0] data_out,
    input logic             int_n,
    input logic             busy
);
    localparam int CONV_CYC = RES_W + 1;
    localparam int RUN_W    = $clog2(CONV_CYC + 2);

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + RUN_W'(1);
        else           run <= '0;
    end

    assert_conv_len_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < RUN_W'(CONV_CYC)));

    assert_int_after_conv_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> $past(busy));

    assert_int_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !int_n |-> !busy);

    assert_wr_clears_int_R8: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_n) |=> int_n);

    assert_rd_clears_int_R8: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !rd_n && !busy) |=> int_n);

    assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(data_out));

endmodule

bind adc_seq_core adc_seq_checker #(.RES_W(RES_W)) u_chk (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
    .data_out(data_out), .int_n(int_n), .busy(busy)
);

// File: tb/adc_seq_core_test.sv
module adc_seq_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [5:0]  ctrl_in = '0;
    logic        bit_in = 1'b0;
    logic [11:0] data_out;
    logic        data_oe, int_n, busy;
    logic [2:0]  mux_ch;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_core uut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
        .ctrl_in(ctrl_in), .bit_in(bit_in), .data_out(data_out),
        .data_oe(data_oe), .int_n(int_n), .busy(busy), .mux_ch(mux_ch)
    );

    function automatic logic [11:0] expect_code(input logic [11:0] raw, input logic bip);
        return bip ? raw : (raw ^ 12'h800);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [5:0] w);
        sel_n = 1'b0; wr_n = 1'b0; ctrl_in = w;
        tick();
        sel_n = 1'b1; wr_n = 1'b1; ctrl_in = '0;
    endtask

    task automatic read_bus(output logic [11:0] v, output logic oe);
        sel_n = 1'b0; rd_n = 1'b0;
        #1;
        v = data_out; oe = data_oe;
        tick();
        sel_n = 1'b1; rd_n = 1'b1;
    endtask

    // Entered at the negedge of the first conversion cycle.
    task automatic run_conv(input logic [11:0] raw);
        tick();
        for (int b = 11; b >= 0; b--) begin
            bit_in = raw[b];
            tick();
        end
        bit_in = 1'b0;
    endtask

    // Entered right after an internally timed write.
    task automatic wait_acq(input string tag);
        tick();
        tick();
        check({tag, " R2 busy low before window end"}, busy, 0);
        tick();
        check({tag, " R2 busy high after window"}, busy, 1);
    endtask

    task automatic full_op(input logic [2:0] ch, input logic bip, input logic ext,
                           input int gap, input logic [5:0] trig_noise, input logic [11:0] raw);
        logic [11:0] v;
        logic oe;
        write_ctrl({1'b0, ext, bip, ch});
        check("R1 mux channel", mux_ch, ch);
        check("R8 write clears flag", int_n, 1);
        if (ext) begin
            repeat (gap) tick();
            check("R4 no conversion before trigger", busy, 0);
            write_ctrl(trig_noise | 6'h20);
            check("R4 busy at trigger", busy, 1);
            check("R4 trigger fields ignored", mux_ch, ch);
        end else begin
            wait_acq("rand");
        end
        run_conv(raw);
        check("R3 flag low at end", int_n, 0);
        check("R3 busy low at end", busy, 0);
        read_bus(v, oe);
        check("R7 oe during read", oe, 1);
        check("R6 result coding", v, expect_code(raw, bip));
        check("R8 read clears flag", int_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] v;
        logic oe;
        int unused_seed;
        unused_seed = $urandom(32'h5EED);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset flag", int_n, 1);
        check("R10 reset busy", busy, 0);
        check("R10 reset mux", mux_ch, 0);
        check("R7 oe idle", data_oe, 0);
        read_bus(v, oe);
        check("R10 reset result", v, 0);

        // Internal window, unipolar
        write_ctrl(6'h05);
        check("R1 channel latched", mux_ch, 5);
        wait_acq("dir");
        run_conv(12'h3A5);
        check("R3 flag after 13 cycles", int_n, 0);
        read_bus(v, oe);
        check("R7 oe", oe, 1);
        check("R6 unipolar", v, 12'hBA5);
        check("R8 read clears", int_n, 1);
        tick();
        check("R7 oe released", data_oe, 0);

        // Bipolar, then a write clears the flag and an abort follows
        write_ctrl(6'h09);
        wait_acq("bip");
        run_conv(12'h812);
        check("R3 flag bipolar", int_n, 0);
        write_ctrl(6'h06);
        check("R8 write clears flag", int_n, 1);
        wait_acq("abort");
        repeat (5) tick();
        read_bus(v, oe);
        check("R9 early read old result", v, 12'h812);
        check("R9 flag unchanged", int_n, 1);
        write_ctrl(6'h02);
        check("R5 busy drops on abort", busy, 0);
        check("R5 new channel", mux_ch, 2);
        wait_acq("restart");
        check("R5 no result from aborted run", int_n, 1);
        run_conv(12'h0F0);
        check("R5 result after restart", int_n, 0);
        read_bus(v, oe);
        check("R5 new settings result", v, 12'h8F0);

        // Host-timed window; trigger carries conflicting fields
        write_ctrl(6'h1B);
        repeat (6) tick();
        check("R4 waits for trigger", busy, 0);
        write_ctrl(6'h24);
        check("R4 busy at trigger", busy, 1);
        check("R4 trigger channel ignored", mux_ch, 3);
        run_conv(12'h7FF);
        check("R4 flag", int_n, 0);
        read_bus(v, oe);
        check("R4 coding from opening write", v, 12'h7FF);

        for (int i = 0; i < 24; i++) begin
            full_op(3'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 5),
                    6'($urandom), 12'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule